// File: doc/BRIEF.md
# ATA PIO Register Cycle Engine

This block is the host-side sequencer for register and programmed-I/O transfers on a 16-bit parallel disk bus. A local request port accepts one transfer at a time. Each request carries a read/write flag, a 5-bit device address and write data. The engine then runs a complete bus cycle. It drives the two active-low chip selects and the three address lines, opens an address setup interval and asserts the read or write strobe. It samples the device ready line at a programmable point inside the strobe and closes the cycle with a hold and a recovery interval. At the end it returns read data together with a one-cycle done pulse.

Every interval is a programmable count of system clocks, supplied on configuration inputs. A device can stretch a cycle by pulling ready low at the sample point. The strobe then stays asserted until ready returns. A watchdog count ends a cycle that is stretched too long and reports a timeout. The DMA acknowledge output is held negated because this engine never runs DMA.

Top module: `pio_cycle_engine`

## Requirements
- R1: During and after reset, until a request is accepted: both chip selects are high (negated), both strobes are high, `ataDataOe` is low, `rspDone` and `rspTimeout` are low and `reqReady` is high.
- R2: An accepted request drives `ataCs1N` = NOT `reqAddr[4]`, `ataCs0N` = NOT `reqAddr[3]` and `ataDa` = `reqAddr[2:0]` from the clock after acceptance. These values stay unchanged through the last recovery cycle, and both chip selects are negated in the cycle where `rspDone` is high.
- R3: After S address setup cycles, the strobe goes low: `ataDiorN` for a read (`reqWrite`=0) or `ataDiowN` for a write (`reqWrite`=1). The other strobe stays high. If ready is high at the sample point, the strobe lasts exactly A cycles. Any count programmed as 0 behaves as 1.
- R4: Ready is examined on the clock edge that ends strobe cycle number Ta (Ta ≤ A). If ready is low there, the strobe stays low until the first edge that sees ready high. The strobe then ends on that edge, even if this is before A cycles.
- R5: For a read, `ataDataIn` is captured on the edge where the strobe ends. In a stretched cycle this is the edge that sees ready high. The captured value is on `rspData` when `rspDone` is high.
- R6: For a write, `ataDataOe` is high and `ataDataOut` equals the request data from the first strobe cycle through H cycles after the strobe ends. At all other times, and for every read, `ataDataOe` is low.
- R7: The strobe is followed by H hold cycles and then R recovery cycles. The chip selects stay asserted through both. `rspDone` is high for exactly one cycle, the cycle after the last recovery cycle.
- R8: If ready is still low on the edge that ends wait cycle number T (the strobe then totals Ta+T cycles), the strobe is released and hold and recovery follow as usual. `rspTimeout` is then high together with `rspDone`.
- R9: `ataDmackN` is high in every cycle.
- R10: `reqValid` is ignored while `reqReady` is low. Such a request changes neither the running cycle's address nor starts a cycle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| cfgSetup | input | CNT_W | Address setup count S |
| cfgActive | input | CNT_W | Nominal strobe width A |
| cfgSample | input | CNT_W | Ready sample point Ta, in strobe cycles |
| cfgHold | input | CNT_W | Write data hold count H |
| cfgRecover | input | CNT_W | Recovery count R |
| cfgWatchdog | input | CNT_W | Maximum wait cycles T |
| reqValid | input | 1 | Request strobe, taken when reqReady is high |
| reqReady | output | 1 | Engine idle and able to accept |
| reqWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| reqAddr | input | 5 | {cs1 select, cs0 select, DA[2:0]} |
| reqWdata | input | DATA_W | Write data |
| rspDone | output | 1 | One-cycle completion pulse |
| rspTimeout | output | 1 | Watchdog ended the cycle, valid with rspDone |
| rspData | output | DATA_W | Captured read data |
| ataCs0N | output | 1 | Chip select 0, active low |
| ataCs1N | output | 1 | Chip select 1, active low |
| ataDa | output | 3 | Device address lines |
| ataDiorN | output | 1 | Read strobe, active low |
| ataDiowN | output | 1 | Write strobe, active low |
| ataDmackN | output | 1 | DMA acknowledge, held negated |
| ataIordy | input | 1 | Device ready |
| ataDataIn | input | DATA_W | Data bus input from pad |
| ataDataOut | output | DATA_W | Data bus output to pad |
| ataDataOe | output | 1 | Data bus output enable |

## Verification
Count from the accepting edge. Every bus output changes on the following edge: the chip selects at once, the strobe after S cycles. The strobe ends A cycles later, or on the edge that sees ready high, or after Ta+T cycles. Hold and recovery follow, and `rspDone` rises after the last recovery cycle. The bench samples at falling edges. It drives ready and data from the number of strobe cycles it has already seen, and classifies each cycle as setup, strobe or post-strobe. At `rspDone` it compares those counts, the captured data and the timeout flag with values it works out from the programmed counts and the ready pattern.

// File: rtl/pio_engine_pkg.sv
package pio_engine_pkg;
  localparam int CS_W   = 2;
  localparam int DA_W   = 3;
  localparam int ADDR_W = CS_W + DA_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_STROBE, ST_WAIT, ST_HOLD, ST_RECOVER
  } pioState_t;

  typedef struct packed {
    logic load;
    logic csOn;
    logic strobeOn;
    logic drive;
    logic capture;
    logic done;
    logic timeout;
  } pioCtrl_t;
endpackage

// File: rtl/pio_engine_ctrl.sv
module pio_engine_ctrl
  import pio_engine_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             curWrite,
  input  logic             iordy,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgActive,
  input  logic [CNT_W-1:0] cfgSample,
  input  logic [CNT_W-1:0] cfgHold,
  input  logic [CNT_W-1:0] cfgRecover,
  input  logic [CNT_W-1:0] cfgWatchdog,
  output logic             reqReady,
  output pioCtrl_t         ctrl
);
  localparam logic [CNT_W:0] ONE = {{CNT_W{1'b0}}, 1'b1};

  pioState_t      state, nextState;
  logic [CNT_W:0] cnt;
  logic           toFlag, toSet, sampleHit;

  function automatic logic reached(input logic [CNT_W:0] c, input logic [CNT_W-1:0] cfg);
    return (c + ONE) >= {1'b0, cfg};
  endfunction

  assign sampleHit = ((cnt + ONE) == {1'b0, cfgSample}) || (cfgSample == '0 && cnt == '0);
  assign reqReady  = (state == ST_IDLE);

  always_comb begin
    nextState    = state;
    toSet        = 1'b0;
    ctrl         = '0;
    case (state)
      ST_IDLE:    if (reqValid) begin nextState = ST_SETUP; ctrl.load = 1'b1; end
      ST_SETUP:   if (reached(cnt, cfgSetup)) nextState = ST_STROBE;
      ST_STROBE: begin
        if (sampleHit && !iordy) nextState = ST_WAIT;
        else if (reached(cnt, cfgActive)) begin nextState = ST_HOLD; ctrl.capture = 1'b1; end
      end
      ST_WAIT: begin
        if (iordy) begin nextState = ST_HOLD; ctrl.capture = 1'b1; end
        else if (reached(cnt, cfgWatchdog)) begin nextState = ST_HOLD; toSet = 1'b1; end
      end
      ST_HOLD:    if (reached(cnt, cfgHold)) nextState = ST_RECOVER;
      ST_RECOVER: if (reached(cnt, cfgRecover)) begin
        nextState    = ST_IDLE;
        ctrl.done    = 1'b1;
        ctrl.timeout = toFlag;
      end
      default:    nextState = ST_IDLE;
    endcase
    ctrl.csOn     = (nextState != ST_IDLE);
    ctrl.strobeOn = (nextState == ST_STROBE) || (nextState == ST_WAIT);
    ctrl.drive    = curWrite && ((nextState == ST_STROBE) || (nextState == ST_WAIT) ||
                                 (nextState == ST_HOLD));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      toFlag <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState != state || nextState == ST_IDLE) cnt <= '0;
      else cnt <= cnt + ONE;
      if (ctrl.load) toFlag <= 1'b0;
      else if (toSet) toFlag <= 1'b1;
    end
  end

  AST_WAIT_FROM_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> ($past(state) == ST_STROBE || $past(state) == ST_WAIT)); // R4
  AST_WAIT_NEEDS_LOW_READY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STROBE && nextState == ST_WAIT) |-> !iordy); // R4
endmodule

// File: rtl/pio_engine_datapath.sv
module pio_engine_datapath
  import pio_engine_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pioCtrl_t          ctrl,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] ataDataIn,
  output logic              curWrite,
  output logic              ataCs0N,
  output logic              ataCs1N,
  output logic [DA_W-1:0]   ataDa,
  output logic              ataDiorN,
  output logic              ataDiowN,
  output logic              ataDmackN,
  output logic [DATA_W-1:0] ataDataOut,
  output logic              ataDataOe,
  output logic [DATA_W-1:0] rspData,
  output logic              rspDone,
  output logic              rspTimeout
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic              csOnQ, strobeQ, oeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curWrite   <= 1'b0;
      addrQ      <= '0;
      wdataQ     <= '0;
      csOnQ      <= 1'b0;
      strobeQ    <= 1'b0;
      oeQ        <= 1'b0;
      rspData    <= '0;
      rspDone    <= 1'b0;
      rspTimeout <= 1'b0;
    end else begin
      if (ctrl.load) begin
        curWrite <= reqWrite;
        addrQ    <= reqAddr;
        wdataQ   <= reqWdata;
      end
      csOnQ      <= ctrl.csOn;
      strobeQ    <= ctrl.strobeOn;
      oeQ        <= ctrl.drive;
      rspDone    <= ctrl.done;
      rspTimeout <= ctrl.timeout;
      if (ctrl.capture && !curWrite) rspData <= ataDataIn;
    end
  end

  assign ataCs1N    = ~(csOnQ & addrQ[ADDR_W-1]);
  assign ataCs0N    = ~(csOnQ & addrQ[ADDR_W-2]);
  assign ataDa      = addrQ[DA_W-1:0];
  assign ataDiorN   = ~(strobeQ & ~curWrite);
  assign ataDiowN   = ~(strobeQ & curWrite);
  assign ataDmackN  = 1'b1;
  assign ataDataOut = wdataQ;
  assign ataDataOe  = oeQ;

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (csOnQ && $past(csOnQ)) |-> $stable(addrQ)); // R2
  AST_STROBE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rstN)
    strobeQ |-> csOnQ); // R3
  AST_CAPTURE_DURING_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capture |-> strobeQ); // R5
  AST_OE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rstN)
    oeQ |-> (csOnQ && curWrite)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone); // R7
  AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    rspTimeout |-> rspDone); // R8
  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |-> !csOnQ); // R10
endmodule

// File: rtl/pio_cycle_engine.sv
module pio_cycle_engine
  import pio_engine_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  cfgSetup,
  input  logic [CNT_W-1:0]  cfgActive,
  input  logic [CNT_W-1:0]  cfgSample,
  input  logic [CNT_W-1:0]  cfgHold,
  input  logic [CNT_W-1:0]  cfgRecover,
  input  logic [CNT_W-1:0]  cfgWatchdog,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [4:0]        reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspDone,
  output logic              rspTimeout,
  output logic [DATA_W-1:0] rspData,
  output logic              ataCs0N,
  output logic              ataCs1N,
  output logic [2:0]        ataDa,
  output logic              ataDiorN,
  output logic              ataDiowN,
  output logic              ataDmackN,
  input  logic              ataIordy,
  input  logic [DATA_W-1:0] ataDataIn,
  output logic [DATA_W-1:0] ataDataOut,
  output logic              ataDataOe
);
  pioCtrl_t ctrl;
  logic     curWrite;

  pio_engine_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .curWrite(curWrite), .iordy(ataIordy),
    .cfgSetup(cfgSetup), .cfgActive(cfgActive), .cfgSample(cfgSample),
    .cfgHold(cfgHold), .cfgRecover(cfgRecover), .cfgWatchdog(cfgWatchdog),
    .reqReady(reqReady), .ctrl(ctrl)
  );

  pio_engine_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .ataDataIn(ataDataIn), .curWrite(curWrite),
    .ataCs0N(ataCs0N), .ataCs1N(ataCs1N), .ataDa(ataDa), .ataDiorN(ataDiorN),
    .ataDiowN(ataDiowN), .ataDmackN(ataDmackN), .ataDataOut(ataDataOut),
    .ataDataOe(ataDataOe), .rspData(rspData), .rspDone(rspDone), .rspTimeout(rspTimeout)
  );
endmodule

// File: tb/test_pio_cycle_engine.sv
module test_pio_cycle_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  cfgSetup, cfgActive, cfgSample, cfgHold, cfgRecover, cfgWatchdog;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [4:0]  reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        reqReady, rspDone, rspTimeout;
  logic [15:0] rspData;
  logic        ataCs0N, ataCs1N, ataDiorN, ataDiowN, ataDmackN, ataDataOe;
  logic [2:0]  ataDa;
  logic        ataIordy = 1'b1;
  logic [15:0] ataDataIn = '0, ataDataOut;
  int          errors = 0, checks = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  pio_cycle_engine i_pio_cycle_engine (
    .clk(clk), .rstN(rstN), .cfgSetup(cfgSetup), .cfgActive(cfgActive),
    .cfgSample(cfgSample), .cfgHold(cfgHold), .cfgRecover(cfgRecover),
    .cfgWatchdog(cfgWatchdog), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .rspDone(rspDone),
    .rspTimeout(rspTimeout), .rspData(rspData), .ataCs0N(ataCs0N), .ataCs1N(ataCs1N),
    .ataDa(ataDa), .ataDiorN(ataDiorN), .ataDiowN(ataDiowN), .ataDmackN(ataDmackN),
    .ataIordy(ataIordy), .ataDataIn(ataDataIn), .ataDataOut(ataDataOut),
    .ataDataOe(ataDataOe)
  );

  task automatic chk(input string req, input bit ok, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int eff(input logic [7:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic setCfg(input int s, input int a, input int ta, input int h, input int r, input int t);
    cfgSetup = 8'(s); cfgActive = 8'(a); cfgSample = 8'(ta);
    cfgHold = 8'(h); cfgRecover = 8'(r); cfgWatchdog = 8'(t);
  endtask

  // One complete bus cycle; L = strobe cycles with ready low (0 = ready always high)
  task automatic runCycle(input bit wr, input logic [4:0] addr, input logic [15:0] wd,
                          input logic [15:0] rd, input int lowLen, input bit pokeBusy,
                          input string name);
    int s, a, ta, h, r, t, expLen, setupCnt, sc, postCnt;
    int addrErr, oeErr, dmackErr, otherErr, iter;
    bit expTo, seenEnd, strobeNow, expOe;
    s = eff(cfgSetup); a = eff(cfgActive); ta = eff(cfgSample);
    h = eff(cfgHold); r = eff(cfgRecover); t = eff(cfgWatchdog);
    if (lowLen <= ta) begin expLen = a; expTo = 0; end
    else if (lowLen <= ta + t) begin expLen = lowLen; expTo = 0; end
    else begin expLen = ta + t; expTo = 1; end
    setupCnt = 0; sc = 0; postCnt = 0; addrErr = 0; oeErr = 0; dmackErr = 0; otherErr = 0;
    seenEnd = 0; iter = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wd;
    ataIordy = (lowLen == 0);
    ataDataIn = ataIordy ? rd : 16'hDEAD;
    @(negedge clk);
    reqValid = 1'b0;
    while (!rspDone && iter < 2000) begin
      strobeNow = wr ? !ataDiowN : !ataDiorN;
      if (wr ? !ataDiorN : !ataDiowN) otherErr++;
      if (ataCs1N !== ~addr[4] || ataCs0N !== ~addr[3] || ataDa !== addr[2:0]) addrErr++;
      if (ataDmackN !== 1'b1) dmackErr++;
      if (strobeNow) begin
        if (seenEnd) otherErr++;
        sc++;
      end else if (sc == 0) setupCnt++;
      else begin seenEnd = 1; postCnt++; end
      expOe = wr && (strobeNow || (seenEnd && postCnt <= h));
      if (ataDataOe !== expOe || (expOe && ataDataOut !== wd)) oeErr++;
      if (pokeBusy) begin
        reqValid = (iter == 2);
        reqAddr  = addr ^ 5'h1F;
      end
      ataIordy = (sc >= lowLen);
      ataDataIn = ataIordy ? rd : 16'hDEAD;
      iter++;
      @(negedge clk);
    end
    reqValid = 1'b0;
    chk("R3", setupCnt == s, setupCnt, s, {name, " setup cycles"});
    chk("R4", sc == expLen, sc, expLen, {name, " strobe cycles"});
    chk("R3", otherErr == 0, otherErr, 0, {name, " wrong or split strobe"});
    chk("R7", postCnt == h + r, postCnt, h + r, {name, " hold+recovery cycles"});
    chk("R2", addrErr == 0, addrErr, 0, {name, " address/cs mismatches"});
    chk("R2", ataCs0N && ataCs1N, {ataCs1N, ataCs0N}, 3, {name, " cs negated at done"});
    chk("R6", oeErr == 0, oeErr, 0, {name, " data drive mismatches"});
    chk("R9", dmackErr == 0, dmackErr, 0, {name, " dmack asserted"});
    chk("R8", rspTimeout == expTo, rspTimeout, expTo, {name, " timeout flag"});
    if (!wr && !expTo) chk("R5", rspData == rd, rspData, rd, {name, " read data"});
    @(negedge clk);
    chk("R7", rspDone == 0, rspDone, 0, {name, " done single pulse"});
    if (pokeBusy) begin
      repeat (4) begin
        chk("R10", ataCs0N && ataCs1N && reqReady, {ataCs1N, ataCs0N, reqReady}, 7,
            {name, " no cycle from busy request"});
        @(negedge clk);
      end
    end
    ataIordy = 1'b1;
  endtask

  task automatic testReset();
    chk("R1", ataCs0N && ataCs1N, {ataCs1N, ataCs0N}, 3, "reset cs");
    chk("R1", ataDiorN && ataDiowN, {ataDiorN, ataDiowN}, 3, "reset strobes");
    chk("R1", !ataDataOe && !rspDone && !rspTimeout, {ataDataOe, rspDone, rspTimeout}, 0, "reset flags");
    chk("R1", reqReady, reqReady, 1, "reset ready");
    chk("R9", ataDmackN, ataDmackN, 1, "reset dmack");
  endtask

  task automatic testPlainWrite();   setCfg(2, 4, 2, 1, 3, 5); runCycle(1, 5'b01_110, 16'hA55A, 16'h0, 0, 0, "plain write"); endtask
  task automatic testPlainRead();    setCfg(3, 5, 2, 2, 2, 5); runCycle(0, 5'b10_011, 16'h0, 16'h1234, 0, 0, "plain read"); endtask
  task automatic testStretchRead();  setCfg(2, 4, 2, 1, 2, 10); runCycle(0, 5'b01_000, 16'h0, 16'hBEEF, 7, 0, "stretched read"); endtask
  task automatic testStretchWrite(); setCfg(1, 3, 1, 2, 1, 10); runCycle(1, 5'b01_101, 16'h0F0F, 16'h0, 6, 0, "stretched write"); endtask
  task automatic testLowBeforeTa();  setCfg(2, 4, 2, 1, 1, 10); runCycle(0, 5'b01_111, 16'h0, 16'h7E81, 2, 0, "ready back at Ta"); endtask
  task automatic testShortStretch(); setCfg(2, 5, 2, 1, 1, 10); runCycle(0, 5'b10_001, 16'h0, 16'h4242, 3, 0, "short stretch"); endtask
  task automatic testTimeout();      setCfg(2, 4, 2, 1, 2, 5); runCycle(0, 5'b01_010, 16'h0, 16'h9999, 100, 0, "timeout"); endtask
  task automatic testTimeoutEdge();  setCfg(2, 4, 2, 1, 2, 5); runCycle(0, 5'b01_100, 16'h0, 16'h3C3C, 7, 0, "ready on last wait"); endtask
  task automatic testZeroCounts();   setCfg(0, 0, 0, 0, 0, 0); runCycle(1, 5'b10_110, 16'hC001, 16'h0, 0, 0, "zero counts"); endtask
  task automatic testZeroTimeout();  setCfg(0, 0, 0, 0, 0, 0); runCycle(0, 5'b01_011, 16'h0, 16'h0, 2, 0, "zero-count timeout"); endtask
  task automatic testBusyRequest();  setCfg(2, 4, 2, 2, 2, 5); runCycle(1, 5'b01_001, 16'h5AA5, 16'h0, 0, 1, "busy request"); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    setCfg(2, 4, 2, 1, 3, 5);
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testPlainWrite();
    testPlainRead();
    testStretchRead();
    testStretchWrite();
    testLowBeforeTa();
    testShortStretch();
    testTimeout();
    testTimeoutEdge();
    testZeroCounts();
    testZeroTimeout();
    testBusyRequest();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule